// File: doc/BRIEF.md
# Ordered Dither Stage

This block reduces the colour depth of a pixel stream just ahead of a display output. Each pixel carries four 8-bit components. Each component can be cut to 6 or 7 bits, or left at 8. To do this the block adds a small threshold that depends on the pixel's screen position, saturates the sum and then drops the low bits. The thresholds come from a 4x4 matrix of 4-bit values that software programs. An optional temporal mode moves the pattern by one step in both directions on each new frame, so the error pattern does not stay fixed on the screen.

Configuration comes in through a write-only register port. Pixels arrive on a valid/ready stream that carries start-of-frame and end-of-line markers. A pixel is taken when `s_valid` and `s_ready` are both high on a clock edge. The output holds its data steady while `m_valid` is high and `m_ready` is low. `s_ready` is high whenever the output stage is empty or is being drained in that cycle, so back-pressure reaches the input within the same cycle. The stream moves one pixel per clock with a fixed two-stage pipeline.

Top module: `ordered_dither`

## Requirements
- R1: A write with `cfg_we` high updates the pending configuration at the byte address `cfg_addr`. At 0x00, bit 0 is the enable. At 0x04, the depth codes for components 0, 1, 2 and 3 sit at bits [1:0], [3:2], [5:4] and [7:6], and bit 8 turns on temporal mode. The four words at 0x08, 0x0C, 0x10 and 0x14 each hold four matrix entries. Word w holds entries 4w to 4w+3, with the lowest-indexed entry in bits [3:0] and the others following in [7:4], [11:8] and [15:12].
- R2: While the dither is not enabled, every pixel leaves the block unchanged, with the same latency and the same markers.
- R3: After reset the enable is 0, all depth codes are 0, temporal mode is off, and the matrix entries 0 to 15 hold 15, 7, 13, 5, 3, 11, 1, 9, 12, 4, 14, 6, 0, 8, 2, 10. Also after reset, `m_valid` is 0 and `s_ready` is 1.
- R4: Component k uses bits [8k+7:8k] of the data word. Depth code 0 gives a 6-bit result and code 1 gives a 7-bit result. In both cases the result is right-justified in its 8-bit lane with the unused upper bits at zero. Codes 2 and 3 pass the component through unchanged.
- R5: A component that loses N bits (N=2 for code 0, N=1 for code 1) becomes min(x + (t >> (4-N)), 255) >> N, where t is the pixel's 4-bit matrix entry.
- R6: The matrix entry is chosen by index 4*(row mod 4) + (column mod 4). A start-of-frame pixel sits at row 0, column 0. The pixel after an end-of-line pixel starts the next row at column 0. Every other pixel moves one column to the right.
- R7: A 2-bit frame counter resets to 0 and steps by one on each accepted start-of-frame pixel. That pixel and the rest of its frame use the new count. In temporal mode the count is added, modulo 4, to both the row and the column before the lookup.
- R8: While the active configuration is enabled, register writes only touch the pending copy. The pending copy becomes active on the next accepted start-of-frame pixel and is already used for that pixel. While the block is not enabled, the pending copy becomes active one cycle after it is written.
- R9: A pixel accepted at clock edge k appears on the output in time for a handshake at edge k+2 if `m_ready` stays high. `m_data`, `m_sof` and `m_eol` stay stable while `m_valid` is high and `m_ready` is low. `s_ready` equals `!m_valid || m_ready`. No pixel is lost or repeated.
- R10: `m_sof` and `m_eol` leave the block together with the pixel they came in with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel ready |
| s_sof | input | 1 | Input pixel is the first of a frame |
| s_eol | input | 1 | Input pixel is the last of a line |
| s_data | input | 32 | Input pixel, four 8-bit components |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Output pixel ready |
| m_sof | output | 1 | Output start-of-frame marker |
| m_eol | output | 1 | Output end-of-line marker |
| m_data | output | 32 | Output pixel, four right-justified components |

## Verification
Each pixel's expected result is computed when the pixel is accepted at edge k and is due at the handshake at edge k+2. The bench marks each expected pixel with its acceptance cycle. If `m_ready` stayed high since that cycle, the bench requires the handshake in exactly that cycle. Otherwise it checks order and content only. Configuration changes are due at the first start-of-frame pixel after the write, or one cycle after the write while the block is disabled. The bench leaves an idle cycle after each write so the pending copy can settle before the next pixel.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int DI_NC = 4;   // components per pixel
  localparam int DI_CW = 8;   // bits per component
  localparam int DI_TW = 4;   // bits per threshold entry
  localparam int DI_SB = 2;   // log2 of matrix side
  localparam int DI_ME = (1 << DI_SB) * (1 << DI_SB);

  typedef struct packed {
    logic                           en;
    logic                           tmp;
    logic [DI_NC-1:0][1:0]          code;
    logic [DI_ME-1:0][DI_TW-1:0]    mat;
  } dcfg_t;

  function automatic dcfg_t dcfg_reset();
    dcfg_t c;
    c.en   = 1'b0;
    c.tmp  = 1'b0;
    c.code = '0;
    c.mat[0]  = 4'd15; c.mat[1]  = 4'd7;  c.mat[2]  = 4'd13; c.mat[3]  = 4'd5;
    c.mat[4]  = 4'd3;  c.mat[5]  = 4'd11; c.mat[6]  = 4'd1;  c.mat[7]  = 4'd9;
    c.mat[8]  = 4'd12; c.mat[9]  = 4'd4;  c.mat[10] = 4'd14; c.mat[11] = 4'd6;
    c.mat[12] = 4'd0;  c.mat[13] = 4'd8;  c.mat[14] = 4'd2;  c.mat[15] = 4'd10;
    return c;
  endfunction
endpackage

// File: rtl/dith_regs.sv
module dith_regs
  import dith_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output dcfg_t         eff,
  output dcfg_t         act
);
  localparam int EPW    = 4;              // entries per matrix word
  localparam int NWORDS = DI_ME / EPW;
  localparam int WIX    = AW - 2;

  dcfg_t pend;
  logic [WIX-1:0] widx;
  logic unused_bits;

  assign widx        = wr_addr[AW-1:2];
  assign unused_bits = ^{wr_addr[1:0], wr_data[DW-1:EPW*DI_TW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= dcfg_reset();
    end else if (wr_en) begin
      if (widx == WIX'(0)) pend.en <= wr_data[0];
      if (widx == WIX'(1)) begin
        pend.code <= wr_data[2*DI_NC-1:0];
        pend.tmp  <= wr_data[2*DI_NC];
      end
      for (int w = 0; w < NWORDS; w++) begin
        if (widx == WIX'(w + 2)) begin
          for (int j = 0; j < EPW; j++)
            pend.mat[w*EPW+j] <= wr_data[j*DI_TW +: DI_TW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              act <= dcfg_reset();
    else if (!act.en || take) act <= pend;
  end

  assign eff = (!act.en || take) ? pend : act;
endmodule

// File: rtl/dith_pos.sv
module dith_pos #(
  parameter int SB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            sof,
  input  logic            eol,
  input  logic            tmp,
  output logic [2*SB-1:0] idx,
  output logic [SB-1:0]   frm_q,
  output logic [SB-1:0]   col_q
);
  logic [SB-1:0] row_q, r, c, f, ri, ci;

  always_comb begin
    r  = sof ? '0 : row_q;
    c  = sof ? '0 : col_q;
    f  = sof ? frm_q + SB'(1) : frm_q;
    ri = tmp ? r + f : r;
    ci = tmp ? c + f : c;
  end

  assign idx = {ri, ci};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      frm_q <= '0;
    end else if (acc) begin
      frm_q <= f;
      if (eol) begin
        col_q <= '0;
        row_q <= r + SB'(1);
      end else begin
        col_q <= c + SB'(1);
        row_q <= r;
      end
    end
  end
endmodule

// File: rtl/dith_lane.sv
module dith_lane #(
  parameter int CW = 8,
  parameter int TW = 4
) (
  input  logic [CW-1:0] x,
  input  logic [TW-1:0] t,
  input  logic [1:0]    code,
  input  logic          en,
  output logic [CW-1:0] y
);
  logic [CW:0]   sum;
  logic [CW-1:0] sat;

  always_comb begin
    sum = '0;
    sat = '0;
    y   = x;
    if (en) begin
      case (code)
        2'd0: begin
          sum = {1'b0, x} + {{(CW+1-TW){1'b0}}, t >> (TW-2)};
          sat = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
          y   = sat >> 2;
        end
        2'd1: begin
          sum = {1'b0, x} + {{(CW+1-TW){1'b0}}, t >> (TW-1)};
          sat = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
          y   = sat >> 1;
        end
        default: y = x;
      endcase
    end
  end
endmodule

// File: rtl/ordered_dither.sv
module ordered_dither
  import dith_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32,
  parameter int PW = DI_NC * DI_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_sof,
  input  logic          s_eol,
  input  logic [PW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_sof,
  output logic          m_eol,
  output logic [PW-1:0] m_data
);
  localparam int IW = 2 * DI_SB;

  logic    adv, acc, take;
  dcfg_t   eff_cfg, act_cfg;
  logic [IW-1:0]    idx;
  logic [DI_SB-1:0] frm_q, col_q;

  logic                  v1, sof1, eol1, en1;
  logic [PW-1:0]         x1;
  logic [DI_TW-1:0]      t1;
  logic [DI_NC-1:0][1:0] code1;
  logic [PW-1:0]         y;

  assign adv     = !m_valid || m_ready;
  assign s_ready = adv;
  assign acc     = s_valid && adv;
  assign take    = acc && s_sof;

  dith_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .take(take), .eff(eff_cfg), .act(act_cfg)
  );

  dith_pos #(.SB(DI_SB)) u_pos (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sof(s_sof), .eol(s_eol),
    .tmp(eff_cfg.tmp), .idx(idx), .frm_q(frm_q), .col_q(col_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; sof1 <= 1'b0; eol1 <= 1'b0; en1 <= 1'b0;
      x1 <= '0; t1 <= '0; code1 <= '0;
    end else if (adv) begin
      v1    <= s_valid;
      sof1  <= s_sof;
      eol1  <= s_eol;
      x1    <= s_data;
      en1   <= eff_cfg.en;
      code1 <= eff_cfg.code;
      t1    <= eff_cfg.mat[idx];
    end
  end

  for (genvar k = 0; k < DI_NC; k++) begin : g_lane
    dith_lane #(.CW(DI_CW), .TW(DI_TW)) u_lane (
      .x(x1[k*DI_CW +: DI_CW]), .t(t1), .code(code1[k]), .en(en1),
      .y(y[k*DI_CW +: DI_CW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0; m_sof <= 1'b0; m_eol <= 1'b0; m_data <= '0;
    end else if (adv) begin
      m_valid <= v1;
      m_sof   <= sof1;
      m_eol   <= eol1;
      m_data  <= y;
    end
  end
endmodule

// File: rtl/dith_chk.sv
module dith_chk
  import dith_pkg::*;
#(
  parameter int PW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_sof,
  input logic             s_eol,
  input logic             m_valid,
  input logic             m_ready,
  input logic             m_sof,
  input logic             m_eol,
  input logic [PW-1:0]    m_data,
  input dcfg_t            act_cfg,
  input logic [DI_SB-1:0] frm,
  input logic [DI_SB-1:0] col
);
  // R9: a stalled output holds its contents
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eol));

  // R9: a full, stalled output refuses new input
  a_r9_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);

  // R7: each accepted frame start advances the frame count by one
  a_r7_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && s_sof |=> frm == $past(frm) + 2'd1);

  // R6: the column restarts after an accepted end-of-line pixel
  a_r6_col_clear: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && s_eol |=> col == '0);

  // R8: an enabled configuration only changes on an accepted frame start
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    act_cfg.en && !(s_valid && s_ready && s_sof) |=> act_cfg == $past(act_cfg));
endmodule

bind ordered_dither dith_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_sof(s_sof), .s_eol(s_eol), .m_valid(m_valid), .m_ready(m_ready),
  .m_sof(m_sof), .m_eol(m_eol), .m_data(m_data), .act_cfg(act_cfg),
  .frm(frm_q), .col(col_q)
);

// File: tb/sim_ordered_dither.sv
`timescale 1ns/1ps
module sim_ordered_dither;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eol = 1'b0, m_ready = 1'b1;
  logic [31:0] s_data = '0;
  logic s_ready, m_valid, m_sof, m_eol;
  logic [31:0] m_data;

  always #2.5 clk = ~clk;

  ordered_dither u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof), .s_eol(s_eol), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_sof(m_sof), .m_eol(m_eol), .m_data(m_data)
  );

  typedef struct { logic [31:0] d; bit sof; bit eol; int cyc; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0, last_stall = -10, rdy_mode = 0;
  string tag = "R3";
  bit done = 0;

  // reference configuration, pending and active
  int p_en, p_tmp, p_code[4], p_mat[16];
  int a_en, a_tmp, a_code[4], a_mat[16];
  int m_row = 0, m_col = 0, m_frm = 0;
  int def_mat[16] = '{15, 7, 13, 5, 3, 11, 1, 9, 12, 4, 14, 6, 0, 8, 2, 10};

  function automatic int dfun(int x, int t, int code, int en);
    int n, v;
    if (en == 0 || code >= 2) return x;
    n = (code == 0) ? 2 : 1;
    v = x + (t >> (4 - n));
    if (v > 255) v = 255;
    return v >> n;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %h expected %h", req, cyc, got, exp);
    end
  endtask

  task automatic tick(output bit acc);
    bit oh;
    case (rdy_mode)
      0: m_ready = 1'b1;
      1: m_ready = (cyc % 3) != 0;
      default: m_ready = (cyc % 5) < 2;
    endcase
    #1;
    acc = s_valid && s_ready;
    oh  = m_valid && m_ready;
    check(s_ready == (!m_valid || m_ready), "R9 ready rule", {31'd0, s_ready}, {31'd0, (!m_valid || m_ready)});
    if (oh) begin
      if (q.size() == 0) check(0, "R9 extra output", m_data, 0);
      else begin
        exp_t e = q.pop_front();
        check(m_data == e.d, tag, m_data, e.d);
        check({m_sof, m_eol} == {e.sof, e.eol}, "R10 markers", {30'd0, m_sof, m_eol}, {30'd0, e.sof, e.eol});
        if (last_stall < e.cyc)
          check(cyc == e.cyc + 2, "R9 latency", cyc, e.cyc + 2);
      end
    end
    if (!m_ready) last_stall = cyc;
    if (acc) begin
      int en, tmp, code[4], mat[16], r, c, f, ri, ci, t;
      exp_t e;
      bit use_p = (a_en == 0) || s_sof;
      en = use_p ? p_en : a_en;  tmp = use_p ? p_tmp : a_tmp;
      for (int i = 0; i < 4; i++) code[i] = use_p ? p_code[i] : a_code[i];
      for (int i = 0; i < 16; i++) mat[i] = use_p ? p_mat[i] : a_mat[i];
      r = s_sof ? 0 : m_row;  c = s_sof ? 0 : m_col;  f = s_sof ? (m_frm + 1) % 4 : m_frm;
      ri = tmp ? (r + f) % 4 : r % 4;  ci = tmp ? (c + f) % 4 : c % 4;
      t = mat[ri * 4 + ci];
      for (int k = 0; k < 4; k++) e.d[k*8 +: 8] = 8'(dfun(int'(s_data[k*8 +: 8]), t, code[k], en));
      e.sof = s_sof; e.eol = s_eol; e.cyc = cyc;
      q.push_back(e);
      m_frm = f;
      if (s_eol) begin m_col = 0; m_row = r + 1; end else begin m_col = c + 1; m_row = r; end
    end
    if (a_en == 0 || (acc && s_sof)) begin
      a_en = p_en; a_tmp = p_tmp; a_code = p_code; a_mat = p_mat;
    end
    if (cfg_we) begin
      int w = int'(cfg_addr) >> 2;
      if (w == 0) p_en = int'(cfg_wdata[0]);
      if (w == 1) begin
        for (int k = 0; k < 4; k++) p_code[k] = int'(cfg_wdata[2*k +: 2]);
        p_tmp = int'(cfg_wdata[8]);
      end
      if (w >= 2 && w <= 5)
        for (int j = 0; j < 4; j++) p_mat[(w-2)*4 + j] = int'(cfg_wdata[4*j +: 4]);
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(int n);
    bit a;
    for (int i = 0; i < n; i++) tick(a);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bit x;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(x);
    cfg_we = 1'b0;
    idle(2);
  endtask

  task automatic send(bit sof, bit eol, logic [31:0] d);
    bit a = 0;
    s_valid = 1'b1; s_sof = sof; s_eol = eol; s_data = d;
    while (!a) tick(a);
    s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0;
    if (d[3:0] == 4'h7) idle(1);
  endtask

  task automatic frame(int rows, int cols, int seed);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++)
        send(r == 0 && c == 0, c == cols - 1, 32'(seed * 32'h9E3779B1 + (r * 37 + c) * 32'h01F3A7C5));
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && q.size() != 0; i++) idle(1);
    check(q.size() == 0, "R9 drain", 32'(q.size()), 0);
  endtask

  initial begin
    p_en = 0; p_tmp = 0; p_code = '{0, 0, 0, 0}; p_mat = def_mat;
    a_en = 0; a_tmp = 0; a_code = '{0, 0, 0, 0}; a_mat = def_mat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(m_valid == 1'b0, "R3 reset valid", {31'd0, m_valid}, 0);
    check(s_ready == 1'b1, "R3 reset ready", {31'd0, s_ready}, 1);
    @(negedge clk);
    tag = "R2 bypass";          frame(3, 5, 1); drain();
    tag = "R3 reset matrix";    wr(5'h00, 1); frame(4, 4, 2); drain();
    tag = "R1 matrix write";
    wr(5'h08, 32'h8F1E); wr(5'h0C, 32'h2D3C); wr(5'h10, 32'h4B5A); wr(5'h14, 32'h6978);
    frame(5, 4, 3); drain();
    tag = "R4 mixed codes";     wr(5'h04, 32'hE4); frame(4, 6, 4); drain();
    tag = "R5 saturation";      wr(5'h04, 32'h00);
    send(1, 0, 32'hFFFEFDFC); send(0, 0, 32'h00FFFEFF); send(0, 1, 32'hFBFCFDFE);
    send(0, 0, 32'hFFFFFFFF); send(0, 1, 32'h01020304);
    wr(5'h04, 32'h55); send(1, 1, 32'hFFFEFDFC); send(0, 1, 32'hFEFEFEFE); drain();
    tag = "R6 positions";       wr(5'h04, 32'h00); frame(6, 7, 5); frame(3, 2, 6); drain();
    tag = "R7 temporal";        wr(5'h04, 32'h100);
    for (int i = 0; i < 5; i++) frame(4, 5, 10 + i);
    drain();
    tag = "R8 frame-held config";
    for (int i = 0; i < 6; i++) send(i == 0, i % 3 == 2, 32'(i * 32'h11335577 + 5));
    wr(5'h04, 32'h55);
    for (int i = 0; i < 6; i++) send(0, i % 3 == 2, 32'(i * 32'h2468ACE1 + 9));
    frame(3, 4, 20);
    send(1, 0, 32'h12345678); wr(5'h00, 0); send(0, 1, 32'h87654321);
    frame(2, 4, 21); drain();
    wr(5'h00, 1);
    tag = "R9 backpressure";    rdy_mode = 1; frame(4, 6, 30); drain();
    rdy_mode = 2; frame(5, 5, 31); wr(5'h04, 32'hE4); frame(3, 3, 32); drain();
    rdy_mode = 0; idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule